// File: doc/BRIEF.md
# Direct-Mode DMA Stream Engine

This block is one DMA stream that runs with its FIFO bypassed. Every request from the peripheral leads to exactly one data item moving between a memory-side bus master port and a peripheral-side bus master port. Both ports carry single beats with a valid/ready handshake. The peripheral learns that its request was served from a one-cycle acknowledge pulse.

Software sets up the direction, the element size, the item count and the two start addresses, then pulses the start input. When the direction is memory to peripheral, the engine reads one item from memory before any request arrives. A request can then be answered straight from the holding register, and the next item is read after that request is acknowledged. When the direction is peripheral to memory, each request causes a peripheral read, then a memory write, then the acknowledge.

Some fields are accepted on the configuration inputs but do nothing in this mode: the memory element size, both burst settings and the FIFO threshold. An illegal setup is refused, and the engine raises an error flag instead of starting.

Top module: `dstream_direct`

## Requirements
- R1: After reset the engine is idle. `busy`, `done`, `per_ack`, `cfg_err`, `mb_valid` and `pb_valid` are all 0, and `remaining` is 0.
- R2: A start pulse with `cfg_dir` set to 2'b10 (memory to memory) or 2'b11 (reserved) sets `cfg_err` and leaves the engine idle, with no beat on either port. The flag stays set until the next start pulse that is legal.
- R3: A start pulse with `cfg_psize` = 2'b11 (reserved) or with `cfg_count` = 0 is refused in the same way as in R2. A legal start clears `cfg_err`.
- R4: With `cfg_dir` = 2'b01 (memory to peripheral), the engine issues exactly one memory read after a legal start, even while no request is pending. It issues no peripheral beat until a request arrives.
- R5: In memory-to-peripheral mode, each peripheral write happens only while `per_req` is high. It carries the item fetched before it, and it is followed by a `per_ack` pulse exactly one cycle long.
- R6: In memory-to-peripheral mode, the total number of memory reads in one transfer equals `cfg_count`. The engine never fetches past the programmed item count.
- R7: With `cfg_dir` = 2'b00 (peripheral to memory), each request causes one peripheral read and then one memory write of the data read. `per_ack` is raised only after that memory write completes.
- R8: Element sizes are encoded 2'b00 = byte, 2'b01 = halfword, 2'b10 = word. Both ports use the size from `cfg_psize`, and `cfg_msize` has no effect. Data moved to either port has the bits above the element width forced to 0.
- R9: `cfg_pburst`, `cfg_mburst` and `cfg_fthresh` have no effect. Every transfer is made of single beats, and the two ports are never active in the same cycle.
- R10: Memory addresses start at `cfg_maddr` and advance by the element size in bytes (1, 2 or 4) after each memory beat. Every peripheral beat uses `cfg_paddr`.
- R11: `remaining` loads `cfg_count` at start and drops by one with each `per_ack`. `done` pulses together with the last acknowledge, and `busy` is low from the following cycle.
- R12: While `valid` is high and `ready` is low on a port, that port holds `valid`, address, direction and write data unchanged.
- R13: A start pulse that arrives while the engine is busy is ignored. The transfer in progress finishes with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_go | input | 1 | Start pulse, sampled only when idle |
| cfg_dir | input | 2 | 00 peripheral to memory, 01 memory to peripheral, 10 memory to memory (illegal), 11 reserved |
| cfg_psize | input | 2 | Element size used by both ports |
| cfg_msize | input | 2 | Memory element size, ignored |
| cfg_pburst | input | 2 | Peripheral burst setting, ignored |
| cfg_mburst | input | 2 | Memory burst setting, ignored |
| cfg_fthresh | input | 2 | FIFO threshold, ignored |
| cfg_count | input | CNT_W | Number of items to move |
| cfg_paddr | input | ADDR_W | Peripheral data address |
| cfg_maddr | input | ADDR_W | First memory address |
| per_req | input | 1 | Peripheral request, held until acknowledged |
| per_ack | output | 1 | One-cycle acknowledge |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Pulses with the last acknowledge |
| cfg_err | output | 1 | Last start attempt was refused |
| remaining | output | CNT_W | Items still to move |
| mb_valid | output | 1 | Memory port beat valid |
| mb_write | output | 1 | Memory beat is a write |
| mb_addr | output | ADDR_W | Memory beat address |
| mb_size | output | 2 | Memory beat size |
| mb_wdata | output | DATA_W | Memory write data |
| mb_ready | input | 1 | Memory port beat accepted |
| mb_rdata | input | DATA_W | Memory read data, valid with ready |
| pb_valid | output | 1 | Peripheral port beat valid |
| pb_write | output | 1 | Peripheral beat is a write |
| pb_addr | output | ADDR_W | Peripheral beat address |
| pb_size | output | 2 | Peripheral beat size |
| pb_wdata | output | DATA_W | Peripheral write data |
| pb_ready | input | 1 | Peripheral port beat accepted |
| pb_rdata | input | DATA_W | Peripheral read data, valid with ready |

## Verification
The bench builds the engine with its default parameters: 32-bit data and addresses and a 16-bit item counter. The 32-bit data width puts byte, halfword and word elements all in reach, so the zeroing of unused bits and the 1-, 2- and 4-byte address steps can each be observed.

Item counts are kept between 1 and 8. This makes the one-item case, where the first prefetch is also the last, appear often, and it lets the stop-at-count rule be checked on every transfer. Ready signals on both ports and the peripheral request timing are randomised, so bus stalls land in every state.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [1:0] {
        DIR_P2M = 2'b00,
        DIR_M2P = 2'b01,
        DIR_M2M = 2'b10,
        DIR_RSV = 2'b11
    } dir_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSV  = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MRD,
        ST_HOLD,
        ST_PWR,
        ST_WREQ,
        ST_PRD,
        ST_MWR,
        ST_ACK
    } state_e;

    typedef struct packed {
        dir_e  dir;
        size_e size;
    } xcfg_t;

    function automatic logic [3:0] size_bytes(size_e sz);
        case (sz)
            SZ_BYTE: return 4'd1;
            SZ_HALF: return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

    function automatic logic [63:0] size_mask(size_e sz);
        case (sz)
            SZ_BYTE: return 64'h0000_0000_0000_00FF;
            SZ_HALF: return 64'h0000_0000_0000_FFFF;
            default: return 64'h0000_0000_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dsd_legal.sv
module dsd_legal
    import dsd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  xcfg_t            cfg,
    input  logic [CNT_W-1:0] count,
    output logic             ok
);
    logic dir_bad;
    logic size_bad;
    logic cnt_bad;

    always_comb begin
        dir_bad  = (cfg.dir == DIR_M2M) || (cfg.dir == DIR_RSV);
        size_bad = (cfg.size == SZ_RSV);
        cnt_bad  = (count == '0);
        ok       = !(dir_bad || size_bad || cnt_bad);
    end
endmodule

// File: rtl/dsd_ctrl.sv
module dsd_ctrl
    import dsd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  logic   legal,
    input  dir_e   go_dir,
    input  dir_e   run_dir,
    input  logic   last,
    input  logic   per_req,
    input  logic   mb_ready,
    input  logic   pb_ready,
    output state_e state,
    output logic   start,
    output logic   mem_step,
    output logic   cap_mem,
    output logic   cap_per,
    output logic   dec,
    output logic   err
);
    state_e nxt;

    always_comb begin
        nxt      = state;
        start    = 1'b0;
        mem_step = 1'b0;
        cap_mem  = 1'b0;
        cap_per  = 1'b0;
        dec      = 1'b0;
        case (state)
            ST_IDLE: if (go && legal) begin
                start = 1'b1;
                nxt   = (go_dir == DIR_M2P) ? ST_MRD : ST_WREQ;
            end
            ST_MRD: if (mb_ready) begin
                mem_step = 1'b1;
                cap_mem  = 1'b1;
                nxt      = ST_HOLD;
            end
            ST_HOLD: if (per_req) nxt = ST_PWR;
            ST_PWR:  if (pb_ready) nxt = ST_ACK;
            ST_WREQ: if (per_req) nxt = ST_PRD;
            ST_PRD: if (pb_ready) begin
                cap_per = 1'b1;
                nxt     = ST_MWR;
            end
            ST_MWR: if (mb_ready) begin
                mem_step = 1'b1;
                nxt      = ST_ACK;
            end
            ST_ACK: begin
                dec = 1'b1;
                if (last)                   nxt = ST_IDLE;
                else if (run_dir == DIR_M2P) nxt = ST_MRD;
                else                         nxt = ST_WREQ;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && go) err <= !legal;
        end
    end
endmodule

// File: rtl/dsd_track.sv
module dsd_track
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xcfg_t             cfg_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [ADDR_W-1:0] paddr_in,
    input  logic [ADDR_W-1:0] maddr_in,
    input  logic              mem_step,
    input  logic              cap_mem,
    input  logic              cap_per,
    input  logic              dec,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [DATA_W-1:0] per_data,
    output xcfg_t             cfg_q,
    output logic [ADDR_W-1:0] maddr_q,
    output logic [ADDR_W-1:0] paddr_q,
    output logic [CNT_W-1:0]  left_q,
    output logic [DATA_W-1:0] hold_q,
    output logic              last
);
    logic [63:0]       mask_wide;
    logic [DATA_W-1:0] mask;
    logic [ADDR_W-1:0] step;

    always_comb begin
        mask_wide = size_mask(cfg_q.size);
        mask      = mask_wide[DATA_W-1:0];
        step      = ADDR_W'(size_bytes(cfg_q.size));
        last      = (left_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            maddr_q <= '0;
            paddr_q <= '0;
            left_q  <= '0;
            hold_q  <= '0;
        end else if (start) begin
            cfg_q   <= cfg_in;
            maddr_q <= maddr_in;
            paddr_q <= paddr_in;
            left_q  <= count_in;
        end else begin
            if (mem_step) maddr_q <= maddr_q + step;
            if (dec)      left_q  <= left_q - CNT_W'(1);
            if (cap_mem)  hold_q  <= mem_data & mask;
            else if (cap_per) hold_q <= per_data & mask;
        end
    end
endmodule

// File: rtl/dstream_direct.sv
module dstream_direct
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_go,
    input  logic [1:0]        cfg_dir,
    input  logic [1:0]        cfg_psize,
    input  logic [1:0]        cfg_msize,
    input  logic [1:0]        cfg_pburst,
    input  logic [1:0]        cfg_mburst,
    input  logic [1:0]        cfg_fthresh,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [ADDR_W-1:0] cfg_paddr,
    input  logic [ADDR_W-1:0] cfg_maddr,
    input  logic              per_req,
    output logic              per_ack,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic [CNT_W-1:0]  remaining,
    output logic              mb_valid,
    output logic              mb_write,
    output logic [ADDR_W-1:0] mb_addr,
    output logic [1:0]        mb_size,
    output logic [DATA_W-1:0] mb_wdata,
    input  logic              mb_ready,
    input  logic [DATA_W-1:0] mb_rdata,
    output logic              pb_valid,
    output logic              pb_write,
    output logic [ADDR_W-1:0] pb_addr,
    output logic [1:0]        pb_size,
    output logic [DATA_W-1:0] pb_wdata,
    input  logic              pb_ready,
    input  logic [DATA_W-1:0] pb_rdata
);
    xcfg_t             cfg_new;
    xcfg_t             cfg_run;
    state_e            state;
    logic              legal, start, mem_step, cap_mem, cap_per, dec, last;
    logic [ADDR_W-1:0] maddr_q, paddr_q;
    logic [DATA_W-1:0] hold_q;
    logic              cfg_unused;

    assign cfg_new    = '{dir: dir_e'(cfg_dir), size: size_e'(cfg_psize)};
    assign cfg_unused = ^{cfg_msize, cfg_pburst, cfg_mburst, cfg_fthresh};

    dsd_legal #(.CNT_W(CNT_W)) u_legal (
        .cfg   (cfg_new),
        .count (cfg_count),
        .ok    (legal)
    );

    dsd_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .go       (cfg_go),
        .legal    (legal),
        .go_dir   (cfg_new.dir),
        .run_dir  (cfg_run.dir),
        .last     (last),
        .per_req  (per_req),
        .mb_ready (mb_ready),
        .pb_ready (pb_ready),
        .state    (state),
        .start    (start),
        .mem_step (mem_step),
        .cap_mem  (cap_mem),
        .cap_per  (cap_per),
        .dec      (dec),
        .err      (cfg_err)
    );

    dsd_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cfg_in   (cfg_new),
        .count_in (cfg_count),
        .paddr_in (cfg_paddr),
        .maddr_in (cfg_maddr),
        .mem_step (mem_step),
        .cap_mem  (cap_mem),
        .cap_per  (cap_per),
        .dec      (dec),
        .mem_data (mb_rdata),
        .per_data (pb_rdata),
        .cfg_q    (cfg_run),
        .maddr_q  (maddr_q),
        .paddr_q  (paddr_q),
        .left_q   (remaining),
        .hold_q   (hold_q),
        .last     (last)
    );

    always_comb begin
        busy     = (state != ST_IDLE);
        per_ack  = (state == ST_ACK);
        done     = per_ack && last;
        mb_valid = (state == ST_MRD) || (state == ST_MWR);
        mb_write = (state == ST_MWR);
        mb_addr  = maddr_q;
        mb_size  = cfg_run.size;
        mb_wdata = hold_q;
        pb_valid = (state == ST_PWR) || (state == ST_PRD);
        pb_write = (state == ST_PWR);
        pb_addr  = paddr_q;
        pb_size  = cfg_run.size;
        pb_wdata = hold_q;
    end
endmodule

// File: rtl/dstream_direct_chk.sv
module dstream_direct_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              per_ack,
    input logic              busy,
    input logic              done,
    input logic              cfg_err,
    input logic [CNT_W-1:0]  remaining,
    input logic              mb_valid,
    input logic              mb_write,
    input logic [ADDR_W-1:0] mb_addr,
    input logic [1:0]        mb_size,
    input logic [DATA_W-1:0] mb_wdata,
    input logic              mb_ready,
    input logic              pb_valid,
    input logic              pb_write,
    input logic [ADDR_W-1:0] pb_addr,
    input logic [1:0]        pb_size,
    input logic [DATA_W-1:0] pb_wdata,
    input logic              pb_ready
);
    p_err_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!busy && !mb_valid && !pb_valid));

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        per_ack |=> !per_ack);

    p_no_overfetch_r6: assert property (@(posedge clk) disable iff (rst)
        (mb_valid && !mb_write) |-> (remaining != '0));

    p_size_r8: assert property (@(posedge clk) disable iff (rst)
        (mb_valid || pb_valid) |-> (mb_size == pb_size && mb_size != 2'b11));

    p_one_port_r9: assert property (@(posedge clk) disable iff (rst)
        !(mb_valid && pb_valid));

    p_dec_r11: assert property (@(posedge clk) disable iff (rst)
        per_ack |=> (remaining == $past(remaining) - CNT_W'(1)));

    p_done_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> (per_ack && remaining == CNT_W'(1)));

    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_mb_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mb_valid && !mb_ready) |=> (mb_valid && $stable(mb_addr) &&
                                     $stable(mb_write) && $stable(mb_wdata)));

    p_pb_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (pb_valid && !pb_ready) |=> (pb_valid && $stable(pb_addr) &&
                                     $stable(pb_write) && $stable(pb_wdata)));
endmodule

bind dstream_direct dstream_direct_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/dstream_direct_tb.sv
module dstream_direct_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_go = 1'b0;
    logic [1:0]    cfg_dir = 2'b00, cfg_psize = 2'b00, cfg_msize = 2'b00;
    logic [1:0]    cfg_pburst = 2'b00, cfg_mburst = 2'b00, cfg_fthresh = 2'b00;
    logic [CW-1:0] cfg_count = '0;
    logic [AW-1:0] cfg_paddr = '0, cfg_maddr = '0;
    logic          per_req = 1'b0;
    logic          per_ack, busy, done, cfg_err;
    logic [CW-1:0] remaining;
    logic          mb_valid, mb_write, mb_ready = 1'b0;
    logic [AW-1:0] mb_addr, pb_addr;
    logic [1:0]    mb_size, pb_size;
    logic [DW-1:0] mb_wdata, mb_rdata, pb_wdata, pb_rdata;
    logic          pb_valid, pb_write, pb_ready = 1'b0;

    int checks = 0, fails = 0, cycles = 0;
    int n_mr, n_mw, n_pr, n_pw, n_ack, n_done, pr_cnt = 0;
    bit pend_pr = 0, req_en = 0, finished = 0;
    logic [1:0]    t_dir, t_sz;
    logic [AW-1:0] t_maddr, t_paddr;
    int            t_cnt;
    logic [DW-1:0] last_prd;

    always #10 clk = ~clk;

    dstream_direct u_dut (.*);

    function automatic logic [DW-1:0] memfn(logic [AW-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction
    function automatic logic [DW-1:0] perfn(int n);
        return (32'(n) * 32'h0100_0193) + 32'hC3C3_00C3;
    endfunction
    function automatic logic [DW-1:0] emask(logic [1:0] sz);
        return (sz == 2'b00) ? 32'hFF : (sz == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic int ebytes(logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    assign mb_rdata = memfn(mb_addr);
    assign pb_rdata = perfn(pr_cnt);

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // bus and peripheral models, monitor
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            chk(0, "watchdog", 64'(cycles), 64'd150000);
            finish_run();
        end
        if (!rst) begin
            if (pend_pr) begin pr_cnt++; pend_pr = 0; end
            mb_ready = ($urandom % 4) != 0;
            pb_ready = ($urandom % 4) != 0;
            if (per_ack) per_req = 1'b0;
            else if (req_en && !per_req && ($urandom % 3) == 0) per_req = 1'b1;
            #1;
            if (per_ack) begin
                // R7 / R5: acknowledge only after the item's last beat
                if (t_dir == 2'b00) chk(n_mw == n_ack + 1, "R7 ack after mem write", 64'(n_mw), 64'(n_ack + 1));
                else                chk(n_pw == n_ack + 1, "R5 ack after per write", 64'(n_pw), 64'(n_ack + 1));
                n_ack++;
            end
            if (done) n_done++;
            if (mb_valid && mb_ready) begin
                int k;
                k = mb_write ? n_mw : n_mr;
                chk(mb_addr == t_maddr + AW'(k * ebytes(t_sz)), "R10 mem addr", 64'(mb_addr),
                    64'(t_maddr + AW'(k * ebytes(t_sz))));
                chk(mb_size == t_sz, "R8 mem size", 64'(mb_size), 64'(t_sz));
                if (mb_write) begin
                    chk(t_dir == 2'b00, "R7 mem write dir", 64'(t_dir), 64'd0);
                    chk(n_pr == n_mw + 1, "R7 read before write", 64'(n_pr), 64'(n_mw + 1));
                    chk(mb_wdata == (last_prd & emask(t_sz)), "R8 mem wdata", 64'(mb_wdata),
                        64'(last_prd & emask(t_sz)));
                    n_mw++;
                end else begin
                    chk(t_dir == 2'b01, "R4 mem read dir", 64'(t_dir), 64'd1);
                    chk(n_mr < t_cnt, "R6 no overfetch", 64'(n_mr), 64'(t_cnt));
                    n_mr++;
                end
            end
            if (pb_valid && pb_ready) begin
                chk(pb_addr == t_paddr, "R10 per addr", 64'(pb_addr), 64'(t_paddr));
                chk(pb_size == t_sz, "R8 per size", 64'(pb_size), 64'(t_sz));
                if (pb_write) begin
                    logic [DW-1:0] e;
                    e = memfn(t_maddr + AW'(n_pw * ebytes(t_sz))) & emask(t_sz);
                    chk(per_req == 1'b1, "R5 write on request", 64'(per_req), 64'd1);
                    chk(n_mr == n_pw + 1, "R5 prefetched item", 64'(n_mr), 64'(n_pw + 1));
                    chk(pb_wdata == e, "R5 per wdata", 64'(pb_wdata), 64'(e));
                    n_pw++;
                end else begin
                    chk(t_dir == 2'b00, "R7 per read dir", 64'(t_dir), 64'd0);
                    last_prd = pb_rdata;
                    pend_pr  = 1;
                    n_pr++;
                end
            end
        end
    end

    task automatic pulse_go();
        @(negedge clk);
        cfg_go = 1'b1;
        @(negedge clk);
        cfg_go = 1'b0;
    endtask

    task automatic run_xfer(logic [1:0] dir, logic [1:0] sz, int cnt, bit prefetch_test, bit busy_go);
        int guard;
        t_dir = dir; t_sz = sz; t_cnt = cnt;
        t_maddr = {$urandom, 2'b00} ;
        t_paddr = $urandom;
        n_mr = 0; n_mw = 0; n_pr = 0; n_pw = 0; n_ack = 0; n_done = 0;
        cfg_dir = dir; cfg_psize = sz; cfg_count = CW'(cnt);
        cfg_maddr = t_maddr; cfg_paddr = t_paddr;
        cfg_msize = 2'($urandom); cfg_pburst = 2'($urandom);   // R9: random ignored fields
        cfg_mburst = 2'($urandom); cfg_fthresh = 2'($urandom);
        req_en = !prefetch_test;
        pulse_go();
        #3;
        chk(cfg_err == 1'b0, "R3 legal start clears err", 64'(cfg_err), 64'd0);
        chk(remaining == CW'(cnt), "R11 count loaded", 64'(remaining), 64'(cnt));
        if (prefetch_test) begin
            repeat (20) @(negedge clk);
            #3;
            chk(n_mr == 1, "R4 one prefetch", 64'(n_mr), 64'd1);
            chk(n_pw == 0, "R4 no per beat without req", 64'(n_pw), 64'd0);
            req_en = 1;
        end
        if (busy_go) begin
            repeat (3) @(negedge clk);
            cfg_dir = ~dir; cfg_count = 16'd99; cfg_maddr = 32'hDEAD_0000;
            pulse_go();
        end
        guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk); #3; guard++;
        end
        req_en = 0;
        @(negedge clk); #3;
        chk(!busy, "R11 idle after done", 64'(busy), 64'd0);
        chk(n_ack == cnt, "R11 ack count", 64'(n_ack), 64'(cnt));
        chk(n_done == 1, "R11 one done pulse", 64'(n_done), 64'd1);
        chk(remaining == '0, "R11 remaining zero", 64'(remaining), 64'd0);
        if (dir == 2'b01) begin
            chk(n_mr == cnt, "R6 reads equal count", 64'(n_mr), 64'(cnt));
            chk(n_pw == cnt, "R5 writes equal count", 64'(n_pw), 64'(cnt));
            chk(n_mw + n_pr == 0, "R9 no other beats", 64'(n_mw + n_pr), 64'd0);
        end else begin
            chk(n_pr == cnt, "R7 reads equal count", 64'(n_pr), 64'(cnt));
            chk(n_mw == cnt, "R7 writes equal count", 64'(n_mw), 64'(cnt));
            chk(n_mr + n_pw == 0, "R9 no other beats", 64'(n_mr + n_pw), 64'd0);
        end
        if (busy_go) chk(n_ack == cnt, "R13 go while busy ignored", 64'(n_ack), 64'(cnt));
    endtask

    task automatic bad_start(logic [1:0] dir, logic [1:0] sz, int cnt, string req);
        int seen;
        n_mr = 0; n_mw = 0; n_pr = 0; n_pw = 0;
        cfg_dir = dir; cfg_psize = sz; cfg_count = CW'(cnt);
        pulse_go();
        seen = 0;
        repeat (6) begin
            @(negedge clk); #3;
            if (busy || mb_valid || pb_valid) seen++;
        end
        chk(cfg_err == 1'b1, req, 64'(cfg_err), 64'd1);
        chk(seen == 0, req, 64'(seen), 64'd0);
    endtask

    initial begin
        void'($urandom(32'h0D5A_11E7));
        t_dir = 2'b00; t_sz = 2'b10; t_cnt = 0; t_maddr = '0; t_paddr = '0;
        last_prd = '0;
        n_mr = 0; n_mw = 0; n_pr = 0; n_pw = 0; n_ack = 0; n_done = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #3;
        // R1
        chk(!busy && !done && !per_ack, "R1 reset ctl", 64'({busy, done, per_ack}), 64'd0);
        chk(!cfg_err && !mb_valid && !pb_valid, "R1 reset bus", 64'({cfg_err, mb_valid, pb_valid}), 64'd0);
        chk(remaining == '0, "R1 reset remaining", 64'(remaining), 64'd0);

        bad_start(2'b10, 2'b10, 4, "R2 mem-to-mem refused");
        run_xfer(2'b01, 2'b10, 3, 1'b1, 1'b0);         // R4 prefetch, also clears err
        bad_start(2'b11, 2'b00, 4, "R2 reserved dir refused");
        bad_start(2'b00, 2'b11, 4, "R3 reserved size refused");
        bad_start(2'b01, 2'b01, 0, "R3 zero count refused");
        run_xfer(2'b01, 2'b00, 1, 1'b1, 1'b0);         // single item, R6 edge
        run_xfer(2'b00, 2'b00, 1, 1'b0, 1'b0);
        run_xfer(2'b00, 2'b01, 5, 1'b0, 1'b1);         // R13
        run_xfer(2'b01, 2'b01, 4, 1'b0, 1'b1);         // R13
        for (int i = 0; i < 30; i++) begin
            run_xfer(2'($urandom % 2), 2'($urandom % 3), 1 + ($urandom % 8), 1'b0, 1'b0);
        end
        finished = 1;
        finish_run();
    end
endmodule